// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from one asynchronous serial line. A sample tick at sixteen times the bit rate enables every sampling step. The block finds a start bit by looking for a low sample that directly follows three high samples. It then counts sample slots 1 to 16 within each bit period and decides each bit by a majority vote of the samples in slots 8, 9 and 10.

Characters are 8 or 9 data bits, least-significant bit first, followed by one stop bit. The slot counter is realigned at each start edge. It is also realigned in mid-frame on any low-going line edge that follows a bit voted high, which lets the receiver tolerate bit-rate mismatch. When a character completes, it is copied into a holding register and a full flag is set. The flag raises an interrupt request when enabled, and a read strobe clears it.

Top module: `serial_rx_16x`

## Requirements
- R1: While rst_ni is low and on release, data_o is 0, bit8_o is 0, full_o is 0 and irq_o is 0.
- R2: A start is accepted only on a tick whose sample is 0 and whose three previous tick samples were all 1; after reset the sample history counts as all 0.
- R3: Each bit value is the majority of the samples at slots 8, 9 and 10 of its period, where slot 1 is the first tick sample of the period; a single wrong sample at slot 9 does not change the value.
- R4: If the start bit's vote is 1, the frame is abandoned and neither the data registers nor full_o change.
- R5: With nine_bit_i low at the start edge, 8 data bits are taken LSB first; data_o holds them and bit8_o is a copy of data bit 7.
- R6: With nine_bit_i high at the start edge, 9 data bits are taken LSB first; data_o holds bits 7..0 and bit8_o holds bit 8.
- R7: full_o is set when a frame's stop bit is voted; a new character arriving while full_o is set replaces data_o and bit8_o and keeps full_o set.
- R8: A cycle with rd_i high and no frame completing clears full_o on the next clock.
- R9: irq_o is high exactly when full_o is high and rie_i is high.
- R10: During data bits, a 1-to-0 line transition after a bit voted 1 restarts the slot count at that edge, so frames whose bit period is 14 or 18 ticks are received correctly when every 0 bit follows a 1 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Sample enable, 16 per bit period |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rie_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Data read strobe, clears full flag |
| data_o | output | 8 | Received data bits 7..0 |
| bit8_o | output | 1 | Ninth bit, or copy of bit 7 in 8-bit mode |
| full_o | output | 1 | Receiver full flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach from the ports is the mid-frame realignment. It only matters once the line's bit period drifts against the receiver's slot count, and only at 1-to-0 transitions. The stimulus sends alternating-bit characters with bit periods of 14 and 18 ticks, so the drift would push the votes into neighbouring bits unless each falling edge pulls the count back, once in the early window and once in the late one. Single-sample glitches at slot 9, a short low pulse that fails its start vote, and low pulses preceded by only two high samples reach the voting and start-search corners in the same way.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  parameter int unsigned SHIFT_W = 9;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;
endpackage

// File: rtl/rx_sampler.sv
module rx_sampler #(
  parameter int unsigned OSR = 16,
  localparam int unsigned SLOT_W = $clog2(OSR + 1),
  localparam int unsigned MID = OSR / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              start_o,
  output logic              fall_o,
  output logic              vote_en_o,
  output logic              vote_o
);
  logic [2:0] hist_q;
  logic       s_a_q, s_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      s_a_q  <= 1'b0;
      s_b_q  <= 1'b0;
    end else if (tick_i) begin
      hist_q <= {hist_q[1:0], rxd_i};
      if (slot_i == SLOT_W'(MID))     s_a_q <= rxd_i;
      if (slot_i == SLOT_W'(MID + 1)) s_b_q <= rxd_i;
    end
  end

  assign start_o   = tick_i && (hist_q == 3'b111) && !rxd_i;
  assign fall_o    = tick_i && hist_q[0] && !rxd_i;
  assign vote_en_o = tick_i && (slot_i == SLOT_W'(MID + 2));
  assign vote_o    = (s_a_q & s_b_q) | (s_a_q & rxd_i) | (s_b_q & rxd_i);

  // r3: two matching early samples decide the vote
  a_r3_vote_majority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vote_en_o && (s_a_q == s_b_q) |-> vote_o == s_a_q);
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16,
  localparam int unsigned SLOT_W = $clog2(OSR + 1),
  localparam int unsigned MID = OSR / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               nine_bit_i,
  input  logic               start_i,
  input  logic               fall_i,
  input  logic               vote_en_i,
  input  logic               vote_i,
  output logic [SLOT_W-1:0]  slot_o,
  output logic               load_o,
  output logic               nine_o,
  output logic [SHIFT_W-1:0] shift_o
);
  rx_state_e           state_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [3:0]          bit_q;
  logic                last_q, nine_q;
  logic [SHIFT_W-1:0]  sh_q;
  logic                early, late, wrap, last_bit;

  always_comb begin
    early    = (state_q == ST_DATA) && fall_i && last_q && (slot_q < SLOT_W'(MID));
    late     = (state_q == ST_DATA) && fall_i && last_q && (slot_q > SLOT_W'(MID + 2));
    wrap     = tick_i && ((slot_q == SLOT_W'(OSR)) || late);
    last_bit = bit_q == (nine_q ? 4'd9 : 4'd8);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      bit_q   <= '0;
      last_q  <= 1'b0;
      nine_q  <= 1'b0;
      sh_q    <= '0;
    end else if (tick_i) begin
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q <= ST_START;
          slot_q  <= SLOT_W'(1);
          nine_q  <= nine_bit_i;
        end
      end else begin
        slot_q <= (wrap || early) ? SLOT_W'(1) : slot_q + SLOT_W'(1);
        unique case (state_q)
          ST_START: begin
            if (vote_en_i && vote_i) state_q <= ST_IDLE;   // false start
            else if (wrap) begin
              state_q <= ST_DATA;
              bit_q   <= '0;
              last_q  <= 1'b0;
            end
          end
          ST_DATA: begin
            if (vote_en_i) begin
              sh_q   <= {vote_i, sh_q[SHIFT_W-1:1]};
              bit_q  <= bit_q + 4'd1;
              last_q <= vote_i;
            end
            if (wrap && last_bit) state_q <= ST_STOP;
          end
          ST_STOP: if (wrap) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign slot_o  = slot_q;
  assign load_o  = (state_q == ST_STOP) && vote_en_i;
  assign nine_o  = nine_q;
  assign shift_o = sh_q;

  a_r2_start_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && state_q == ST_IDLE && start_i |=> state_q == ST_START && slot_q == SLOT_W'(1));
  a_r4_false_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && state_q == ST_START && vote_en_i && vote_i |=> state_q == ST_IDLE);
  a_r10_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE |-> slot_q >= SLOT_W'(1) && slot_q <= SLOT_W'(OSR));
  a_r10_early_realign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && state_q == ST_DATA && fall_i && last_q && slot_q < SLOT_W'(MID)
    |=> slot_q == SLOT_W'(1));
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
  import serial_rx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               nine_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               rd_i,
  input  logic               rie_i,
  output logic [7:0]         data_o,
  output logic               bit8_o,
  output logic               full_o,
  output logic               irq_o
);
  logic [7:0] data_q;
  logic       bit8_q, full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      bit8_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (load_i) begin
        data_q <= nine_i ? shift_i[7:0] : shift_i[8:1];
        bit8_q <= shift_i[8];  // ninth bit, or bit 7 in 8-bit mode
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign bit8_o = bit8_q;
  assign full_o = full_q;
  assign irq_o  = full_q & rie_i;

  a_r7_load_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> full_q);
  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !load_i |=> !full_q);
  a_r7_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_q) && $stable(bit8_q));
  a_r9_irq_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> full_q);
endmodule

// File: rtl/serial_rx_16x.sv
module serial_rx_16x
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16,
  localparam int unsigned SLOT_W = $clog2(OSR + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  input  logic       tick_i,
  input  logic       nine_bit_i,
  input  logic       rie_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       bit8_o,
  output logic       full_o,
  output logic       irq_o
);
  logic [SLOT_W-1:0]  slot;
  logic               start, fall, vote_en, vote, load, nine;
  logic [SHIFT_W-1:0] shift;

  rx_sampler #(.OSR(OSR)) u_sampler (
    .clk_i, .rst_ni, .tick_i, .rxd_i,
    .slot_i(slot), .start_o(start), .fall_o(fall),
    .vote_en_o(vote_en), .vote_o(vote)
  );

  rx_frame #(.OSR(OSR)) u_frame (
    .clk_i, .rst_ni, .tick_i, .nine_bit_i,
    .start_i(start), .fall_i(fall), .vote_en_i(vote_en), .vote_i(vote),
    .slot_o(slot), .load_o(load), .nine_o(nine), .shift_o(shift)
  );

  rx_buffer u_buffer (
    .clk_i, .rst_ni, .load_i(load), .nine_i(nine), .shift_i(shift),
    .rd_i, .rie_i, .data_o, .bit8_o, .full_o, .irq_o
  );
endmodule

// File: tb/serial_rx_16x_tb.sv
module serial_rx_16x_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b0, tick = 1'b0;
  logic nine = 1'b0, rie = 1'b1, rd = 1'b0;
  logic [7:0] data;
  logic bit8, full, irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) tick <= ~tick;   // one tick every two clocks

  serial_rx_16x u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick_i(tick),
    .nine_bit_i(nine), .rie_i(rie), .rd_i(rd),
    .data_o(data), .bit8_o(bit8), .full_o(full), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input int per, input bit glitch);
    if (glitch) begin
      hold(v, 8); hold(~v, 1); hold(v, per - 9);
    end else hold(v, per);
  endtask

  task automatic send_frame(input logic [8:0] v, input bit nb, input int per, input bit glitch);
    nine = nb;
    send_bit(1'b0, per, 1'b0);
    for (int i = 0; i < (nb ? 9 : 8); i++) send_bit(v[i], per, glitch);
    send_bit(1'b1, per, 1'b0);
    hold(1'b1, 4);
  endtask

  task automatic read_clear(input string tag);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
    check(full == 1'b0, tag, full, 0);
  endtask

  task automatic check_char(input logic [8:0] v, input bit nb, input string tag);
    logic [8:0] exp;
    exp = nb ? v : {v[7], v[7:0]};
    check(data == exp[7:0], tag, data, exp[7:0]);
    check(bit8 == exp[8], tag, bit8, exp[8]);
    check(full == 1'b1, tag, full, 1);
    check(irq == rie, "R9", irq, rie);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(data == 8'h00 && bit8 == 1'b0, "R1", {bit8, data}, 0);
    check(full == 1'b0 && irq == 1'b0, "R1", {full, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(full == 1'b0 && data == 8'h00, "R1", {full, data}, 0);

    // R2: low pulses preceded by only two high samples never start a frame
    hold(1'b0, 20); hold(1'b1, 2); hold(1'b0, 20); hold(1'b1, 40);
    check(full == 1'b0, "R2", full, 0);

    // R5: all 8-bit values
    for (int v = 0; v < 256; v++) begin
      send_frame(9'(v), 1'b0, 16, 1'b0);
      check_char(9'(v), 1'b0, "R5");
      read_clear("R8");
    end

    // R6: 9-bit values spread over the range
    for (int i = 0; i < 64; i++) begin
      send_frame(9'(i * 8 + 3), 1'b1, 16, 1'b0);
      check_char(9'(i * 8 + 3), 1'b1, "R6");
      read_clear("R8");
    end

    // R3: every data bit inverted at slot 9 only
    send_frame(9'h0A5, 1'b0, 16, 1'b1);
    check_char(9'h0A5, 1'b0, "R3");
    send_frame(9'h15A, 1'b1, 16, 1'b1);
    check_char(9'h15A, 1'b1, "R3");
    read_clear("R8");

    // R4: short low pulse fails its start vote, registers untouched
    hold(1'b0, 4); hold(1'b1, 40);
    check(full == 1'b0, "R4", full, 0);
    check(data == 8'h5A && bit8 == 1'b1, "R4", {bit8, data}, 9'h15A);

    // R7: overwrite while full; R9: irq off with rie low
    send_frame(9'h03C, 1'b0, 16, 1'b0);
    send_frame(9'h0C3, 1'b0, 16, 1'b0);
    check_char(9'h0C3, 1'b0, "R7");
    rie = 1'b0;
    @(negedge clk);
    check(irq == 1'b0 && full == 1'b1, "R9", {full, irq}, 2);
    rie = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R9", irq, 1);
    read_clear("R8");
    check(irq == 1'b0, "R9", irq, 0);

    // R10: slow and fast line bit periods
    send_frame(9'h055, 1'b0, 18, 1'b0);
    check_char(9'h055, 1'b0, "R10");
    read_clear("R8");
    send_frame(9'h055, 1'b0, 14, 1'b0);
    check_char(9'h055, 1'b0, "R10");
    read_clear("R8");
    send_frame(9'h155, 1'b1, 18, 1'b0);
    check_char(9'h155, 1'b1, "R10");
    read_clear("R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule